// File: doc/BRIEF.md
# Source Retransmission Transaction Buffer

This block sits between a core's packet injection port and an on-chip network that may drop packets when a router preempts them in favour of higher-priority traffic. Every packet the core injects is copied into a local store and given a 5-bit tag, which travels with it into the network. The copy is kept until a separate, narrow acknowledgement network returns a positive or negative answer carrying that tag. Recovery relies only on these answers and uses no timers.

A positive answer releases the packet's flit space and its tag. A negative answer means the packet was dropped in the network. The block then queues the stored copy for reinjection, and reinjected packets go out ahead of new ones. Packets are one or four flits long, and the store is budgeted in flits (30 by default) rather than in packets. The core is held off whenever the remaining space cannot take the packet it presents. An answer that names a tag not currently awaiting one raises a one-cycle error flag and changes nothing else.

Top module: `retx_txn_buffer`

## Requirements
- R1: After reset, `idle`=1, `out_valid`=0, `err`=0, `free_flits`=30, and `in_ready`=1 for a packet of either length.
- R2: Each injected packet is sent on the output with its flits in injection order and its data unchanged. `out_last` is set on the final flit, and `out_tag` is the lowest-numbered tag that was free when the packet's first flit was accepted.
- R3: `free_flits` drops by the packet length (1 when `in_long`=0, 4 when `in_long`=1) in the cycle after the first flit is accepted. It rises by the same amount in the cycle after a positive answer. It never exceeds 30.
- R4: Between packets, `in_ready` is 0 when `free_flits` is smaller than the length of the presented packet. Once a packet's first flit is taken, its remaining flits are always accepted.
- R5: A positive answer (`ack_nack`=0) for a tag that has been fully sent frees that tag. A second answer for the same tag raises `err`.
- R6: A negative answer (`ack_nack`=1) for a fully sent tag causes the same flits to be sent again under the same tag with `out_retx`=1, with no change to `free_flits`.
- R7: Packets waiting for reinjection are sent before any new packet. Among themselves they go in the order their negative answers arrived.
- R8: An answer whose tag is free, still filling, or queued or being sent sets `err` to 1 for exactly the next cycle. It changes neither `free_flits` nor the output.
- R9: `idle` is 1 exactly when no packet is held, and `out_valid` is 0 while `idle` is 1.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_tag` and `out_retx` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Core presents a flit |
| in_ready | output | 1 | Flit accepted this cycle when high with in_valid |
| in_long | input | 1 | Packet length: 0 = one flit, 1 = four flits; held for the whole packet |
| in_data | input | 32 | Flit payload from the core |
| out_valid | output | 1 | Flit offered to the network |
| out_ready | input | 1 | Network takes the offered flit |
| out_data | output | 32 | Flit payload to the network |
| out_tag | output | 5 | Tag of the packet being sent |
| out_last | output | 1 | Final flit of the packet |
| out_retx | output | 1 | Packet is a reinjection after a negative answer |
| ack_valid | input | 1 | Answer present from the acknowledgement network |
| ack_nack | input | 1 | 0 = delivered, 1 = dropped |
| ack_tag | input | 5 | Tag the answer refers to |
| free_flits | output | 5 | Unreserved flit space |
| idle | output | 1 | No packet held |
| err | output | 1 | Previous-cycle answer named a tag not awaiting one |

## Verification
Several properties are checked on every cycle. The space count never exceeds its limit, and a new packet is refused between packets when space is short. Taking a first flit lowers the count by exactly the packet length. The output holds steady under backpressure and stays quiet while idle, and the error flag only follows an answer. Other behaviours only show up across the bench's scenarios: which tag a packet receives, the payload carried by a reinjection, the reinjection order after several drops, and the error flag for answers to queued or already freed tags. The bench tracks these with a transaction model under a seeded random mix of traffic and answers, plus directed fill-to-full and reordering cases.

// File: rtl/retx_txn_buffer.sv
module retx_txn_buffer #(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 5,
  parameter int FLIT_CAP = 30,
  parameter int LONG_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_long,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DATA_W-1:0]             out_data,
  output logic [TAG_W-1:0]              out_tag,
  output logic                          out_last,
  output logic                          out_retx,
  input  logic                          ack_valid,
  input  logic                          ack_nack,
  input  logic [TAG_W-1:0]              ack_tag,
  output logic [$clog2(FLIT_CAP+1)-1:0] free_flits,
  output logic                          idle,
  output logic                          err
);
  localparam int NTAG  = 1 << TAG_W;
  localparam int IDX_W = $clog2(LONG_LEN);
  localparam int CNT_W = $clog2(FLIT_CAP + 1);
  localparam int QC_W  = TAG_W + 1;

  typedef enum logic [1:0] {S_FREE, S_FILL, S_QUEUED, S_FLIGHT} tstate_t;

  tstate_t           st  [NTAG];
  logic              lng [NTAG];
  logic [DATA_W-1:0] mem [NTAG][LONG_LEN];
  logic [TAG_W-1:0]  nq  [NTAG];
  logic [TAG_W-1:0]  rq  [NTAG];

  logic [TAG_W-1:0] nq_wp, nq_rp, rq_wp, rq_rp;
  logic [QC_W-1:0]  nq_cnt, rq_cnt;

  logic             in_busy, wr_long;
  logic [TAG_W-1:0] wr_tag;
  logic [IDX_W-1:0] wr_idx;

  logic             sd_busy, sd_retx;
  logic [TAG_W-1:0] sd_tag;
  logic [IDX_W-1:0] sd_idx;

  logic [CNT_W-1:0] free_q;
  logic             err_q;

  logic             fr_hit;
  logic [TAG_W-1:0] fr_tag;

  always_comb begin
    fr_hit = 1'b0;
    fr_tag = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        fr_hit = 1'b1;
        fr_tag = TAG_W'(i);
      end
    end
  end

  logic [CNT_W-1:0] need_len, ack_len;
  logic             in_fire, first, cur_long, in_done;
  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W-1:0] cur_idx;

  assign need_len = in_long ? CNT_W'(LONG_LEN) : CNT_W'(1);
  assign in_ready = in_busy | (fr_hit & (free_q >= need_len));
  assign in_fire  = in_valid & in_ready;
  assign first    = in_fire & ~in_busy;
  assign cur_tag  = in_busy ? wr_tag  : fr_tag;
  assign cur_idx  = in_busy ? wr_idx  : '0;
  assign cur_long = in_busy ? wr_long : in_long;
  assign in_done  = in_fire & (~cur_long | (cur_idx == IDX_W'(LONG_LEN - 1)));

  logic out_fire, sd_done, load, load_r;
  logic ack_ok, ack_bad, ack_free;
  logic nq_push, nq_pop, rq_push, rq_pop;

  assign out_valid = sd_busy;
  assign out_data  = mem[sd_tag][sd_idx];
  assign out_tag   = sd_tag;
  assign out_retx  = sd_retx;
  assign out_last  = sd_idx == (lng[sd_tag] ? IDX_W'(LONG_LEN - 1) : '0);
  assign out_fire  = out_valid & out_ready;
  assign sd_done   = out_fire & out_last;

  assign load   = ~sd_busy & ((rq_cnt != '0) | (nq_cnt != '0));
  assign load_r = rq_cnt != '0;

  assign ack_ok   = ack_valid & (st[ack_tag] == S_FLIGHT);
  assign ack_bad  = ack_valid & ~ack_ok;
  assign ack_free = ack_ok & ~ack_nack;
  assign ack_len  = lng[ack_tag] ? CNT_W'(LONG_LEN) : CNT_W'(1);

  assign nq_push = in_done;
  assign nq_pop  = load & ~load_r;
  assign rq_push = ack_ok & ack_nack;
  assign rq_pop  = load & load_r;

  assign free_flits = free_q;
  assign idle       = free_q == CNT_W'(FLIT_CAP);
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (in_fire) mem[cur_tag][cur_idx] <= in_data;
    if (first) lng[fr_tag] <= in_long;
    if (nq_push) nq[nq_wp] <= cur_tag;
    if (rq_push) rq[rq_wp] <= ack_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAG; i++) st[i] <= S_FREE;
      in_busy <= 1'b0;
      wr_long <= 1'b0;
      wr_tag  <= '0;
      wr_idx  <= '0;
      sd_busy <= 1'b0;
      sd_retx <= 1'b0;
      sd_tag  <= '0;
      sd_idx  <= '0;
      nq_wp   <= '0;
      nq_rp   <= '0;
      rq_wp   <= '0;
      rq_rp   <= '0;
      nq_cnt  <= '0;
      rq_cnt  <= '0;
      free_q  <= CNT_W'(FLIT_CAP);
      err_q   <= 1'b0;
    end else begin
      if (first) begin
        wr_tag  <= fr_tag;
        wr_long <= in_long;
      end
      if (in_fire) begin
        st[cur_tag] <= in_done ? S_QUEUED : S_FILL;
        in_busy     <= ~in_done;
        wr_idx      <= in_done ? '0 : cur_idx + 1'b1;
      end
      if (sd_done) st[sd_tag] <= S_FLIGHT;
      if (ack_ok)  st[ack_tag] <= ack_nack ? S_QUEUED : S_FREE;

      if (load) begin
        sd_busy <= 1'b1;
        sd_idx  <= '0;
        sd_retx <= load_r;
        sd_tag  <= load_r ? rq[rq_rp] : nq[nq_rp];
      end else if (out_fire) begin
        if (out_last) sd_busy <= 1'b0;
        else          sd_idx  <= sd_idx + 1'b1;
      end

      if (nq_push) nq_wp <= nq_wp + 1'b1;
      if (nq_pop)  nq_rp <= nq_rp + 1'b1;
      if (rq_push) rq_wp <= rq_wp + 1'b1;
      if (rq_pop)  rq_rp <= rq_rp + 1'b1;
      nq_cnt <= nq_cnt + QC_W'(nq_push) - QC_W'(nq_pop);
      rq_cnt <= rq_cnt + QC_W'(rq_push) - QC_W'(rq_pop);

      free_q <= free_q - (first ? need_len : '0) + (ack_free ? ack_len : '0);
      err_q  <= ack_bad;
    end
  end
endmodule

// File: rtl/retx_txn_buffer_chk.sv
module retx_txn_buffer_chk #(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 5,
  parameter int FLIT_CAP = 30,
  parameter int LONG_LEN = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          in_long,
  input logic                          in_busy,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [DATA_W-1:0]             out_data,
  input logic [TAG_W-1:0]              out_tag,
  input logic                          out_retx,
  input logic                          ack_valid,
  input logic [$clog2(FLIT_CAP+1)-1:0] free_flits,
  input logic                          idle,
  input logic                          err
);
  a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_flits) <= FLIT_CAP);

  a_r3_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_busy && !ack_valid) |=>
      int'(free_flits) == int'($past(free_flits)) - ($past(in_long) ? LONG_LEN : 1));

  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_busy && int'(free_flits) < (in_long ? LONG_LEN : 1)) |-> !in_ready);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(ack_valid));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_retx)));
endmodule

bind retx_txn_buffer retx_txn_buffer_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .FLIT_CAP(FLIT_CAP), .LONG_LEN(LONG_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_long(in_long), .in_busy(in_busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
  .out_retx(out_retx), .ack_valid(ack_valid), .free_flits(free_flits),
  .idle(idle), .err(err)
);

// File: tb/retx_txn_buffer_tb_top.sv
`timescale 1ns/1ps
module retx_txn_buffer_tb_top;
  localparam int DW = 32, TW = 5, CAP = 30, LL = 4, NT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_ready, in_long = 0, out_valid, out_ready = 0;
  logic out_last, out_retx, ack_valid = 0, ack_nack = 0, idle, err;
  logic [DW-1:0] in_data = '0, out_data;
  logic [TW-1:0] out_tag, ack_tag = '0;
  logic [4:0] free_flits;

  retx_txn_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_long(in_long), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .out_last(out_last), .out_retx(out_retx), .ack_valid(ack_valid),
    .ack_nack(ack_nack), .ack_tag(ack_tag), .free_flits(free_flits),
    .idle(idle), .err(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st [NT];
  int m_len[NT];
  int m_oidx[NT];
  bit m_rtx[NT];
  logic [DW-1:0] m_dat[NT][LL];
  int m_free = CAP, m_done = 0;
  bit exp_err = 0;
  bit b_busy = 0, b_long = 0;
  int b_tag = 0, b_idx = 0, b_len = 1;
  bit prev_hold = 0;
  logic [DW-1:0] prev_data;
  logic [TW-1:0] prev_tag;
  int log_tag[64];
  bit log_rtx[64];
  int log_n = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < NT; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int pick_flight();
    int s = $urandom % NT;
    for (int i = 0; i < NT; i++) if (m_st[(s + i) % NT] == 3) return (s + i) % NT;
    return -1;
  endfunction

  function automatic int count_state(int s);
    int c = 0;
    for (int i = 0; i < NT; i++) if (m_st[i] == s) c++;
    return c;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // Called just after a falling edge; returns at the next falling edge.
  task automatic step(bit iv, bit il, logic [DW-1:0] id, bit ordy, bit av, bit an, int at);
    bit exp_rdy, ack_good, exp_err_n;
    int t;
    chk(free_flits == m_free, "R3 free space", free_flits, m_free);
    chk(idle == (m_free == CAP), "R9 idle flag", idle, m_free == CAP);
    chk(err == exp_err, "R8 error flag", err, exp_err);
    if (prev_hold)
      chk(out_valid && out_data == prev_data && out_tag == prev_tag, "R10 output hold", out_tag, prev_tag);
    in_valid = iv; in_long = b_busy ? b_long : il; in_data = id;
    out_ready = ordy; ack_valid = av; ack_nack = an; ack_tag = TW'(at);
    #1;
    exp_rdy = b_busy || (m_free >= (il ? LL : 1));
    if (iv) chk(in_ready == exp_rdy, "R4 injection ready", in_ready, exp_rdy);
    ack_good  = av && m_st[at] == 3;
    exp_err_n = av && !ack_good;
    if (iv && in_ready) begin
      if (!b_busy) begin
        b_tag = low_free(); b_long = il; b_len = il ? LL : 1; b_idx = 0;
        m_len[b_tag] = b_len; m_free -= b_len; m_st[b_tag] = 1;
      end
      m_dat[b_tag][b_idx] = id;
      b_idx++;
      if (b_idx == b_len) begin
        m_st[b_tag] = 2; m_rtx[b_tag] = 0; m_oidx[b_tag] = 0; b_busy = 0; m_done++;
      end else b_busy = 1;
    end
    prev_hold = out_valid && !ordy;
    prev_data = out_data; prev_tag = out_tag;
    if (out_valid && ordy) begin
      t = int'(out_tag);
      chk(m_st[t] == 2, "R2 sent tag pending", m_st[t], 2);
      if (m_oidx[t] < LL) begin
        chk(out_data == m_dat[t][m_oidx[t]], "R2 flit data", out_data, m_dat[t][m_oidx[t]]);
        chk(out_last == (m_oidx[t] == m_len[t] - 1), "R2 last flit", out_last, m_oidx[t] == m_len[t] - 1);
      end
      chk(out_retx == m_rtx[t], "R6 reinjection flag", out_retx, m_rtx[t]);
      if (m_oidx[t] == 0 && log_n < 64) begin
        log_tag[log_n] = t; log_rtx[log_n] = out_retx; log_n++;
      end
      m_oidx[t]++;
      if (out_last) m_st[t] = 3;
    end
    if (ack_good) begin
      if (an) begin m_st[at] = 2; m_rtx[at] = 1; m_oidx[at] = 0; end
      else begin m_st[at] = 0; m_free += m_len[at]; end
    end
    exp_err = exp_err_n;
    @(negedge clk);
  endtask

  task automatic inject_pkt(bit lng, bit ordy);
    int c = m_done;
    for (int k = 0; k < 40 && m_done == c; k++) step(1, lng, $urandom, ordy, 0, 0, 0);
  endtask

  task automatic idle_steps(int n, bit ordy);
    for (int k = 0; k < n; k++) step(0, 0, '0, ordy, 0, 0, 0);
  endtask

  task automatic ack_all();
    for (int k = 0; k < 200; k++) begin
      int t = pick_flight();
      if (t < 0 && count_state(2) == 0) break;
      if (t >= 0) step(0, 0, '0, 1, 1, 0, t);
      else step(0, 0, '0, 1, 0, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NT; i++) begin m_st[i] = 0; m_len[i] = 1; m_oidx[i] = 0; m_rtx[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(idle == 1, "R1 idle after reset", idle, 1);
    chk(out_valid == 0, "R1 no output after reset", out_valid, 0);
    chk(err == 0, "R1 error clear after reset", err, 0);
    chk(free_flits == CAP, "R1 full space after reset", free_flits, CAP);
    in_long = 1; #1;
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);

    // R8 answer for a free tag while idle
    step(0, 0, '0, 1, 1, 0, 7);
    chk(err == 1 && out_valid == 0, "R8 free tag flagged, no output", err, 1);
    step(0, 0, '0, 1, 0, 0, 0);

    // R4 fill to capacity with the output blocked
    for (int p = 0; p < 7; p++) inject_pkt(1, 0);
    step(0, 0, '0, 0, 1, 1, 1);
    chk(err == 1, "R8 queued tag flagged", err, 1);
    step(1, 1, $urandom, 0, 0, 0, 0);
    chk(free_flits == 2, "R4 long packet refused", free_flits, 2);
    inject_pkt(0, 0);
    inject_pkt(0, 0);
    step(1, 0, $urandom, 0, 0, 0, 0);
    chk(free_flits == 0, "R4 short packet refused when full", free_flits, 0);
    for (int k = 0; k < 200 && count_state(3) < 9; k++) step(0, 0, '0, ($urandom % 3) != 0, 0, 0, 0);
    chk(count_state(3) == 9, "R2 all packets sent", count_state(3), 9);

    // R5 release and duplicate answer
    step(0, 0, '0, 1, 1, 0, 0);
    step(0, 0, '0, 1, 1, 0, 0);
    chk(err == 1, "R5 duplicate answer flagged", err, 1);
    chk(free_flits == 4, "R5 space returned once", free_flits, 4);
    ack_all();
    step(0, 0, '0, 1, 0, 0, 0);
    chk(idle == 1, "R9 idle after all released", idle, 1);

    // R7 reinjection ordering
    for (int p = 0; p < 3; p++) inject_pkt(0, 1);
    idle_steps(12, 1);
    step(0, 0, '0, 0, 1, 1, 2);
    step(0, 0, '0, 0, 1, 1, 0);
    inject_pkt(0, 0);
    chk(free_flits == CAP - 4, "R6 no space taken by drops", free_flits, CAP - 4);
    log_n = 0;
    idle_steps(15, 1);
    chk(log_n == 3, "R7 three packets started", log_n, 3);
    chk(log_tag[0] == 2 && log_rtx[0], "R7 first reinjection", log_tag[0], 2);
    chk(log_tag[1] == 0 && log_rtx[1], "R7 second reinjection", log_tag[1], 0);
    chk(log_tag[2] == 3 && !log_rtx[2], "R7 new packet after drops", log_tag[2], 3);
    ack_all();

    // Random mix of traffic and answers
    for (int k = 0; k < 5000; k++) begin
      bit iv, av, an;
      int at, r;
      iv = b_busy ? (($urandom % 4) != 0) : (($urandom % 3) == 0);
      av = 0; an = 0; at = 0;
      r = $urandom % 10;
      if (r < 4) begin
        at = pick_flight();
        if (at >= 0) begin av = 1; an = ($urandom % 4) == 0; end else at = 0;
      end else if (r == 9) begin
        av = 1; an = $urandom % 2; at = $urandom % NT;
      end
      step(iv, $urandom % 2, $urandom, ($urandom % 4) != 0, av, an, at);
    end

    // Drain
    for (int k = 0; k < 40 && b_busy; k++) step(1, b_long, $urandom, 1, 0, 0, 0);
    ack_all();
    step(0, 0, '0, 1, 0, 0, 0);
    chk(idle == 1 && free_flits == CAP, "R9 idle after drain", free_flits, CAP);

    summary();
    $finish;
  end
endmodule